// File: doc/BRIEF.md
# Clock Synthesizer Reconfiguration Sequencer

This block drives the serial scan chain of a clock synthesizer so that a new set of divider and loop settings can be loaded while the device runs. A host presents a configuration word and a flag on parallel inputs, then pulses `start`. The sequencer captures both values. It raises the chain's shift enable and holds it high for one idle cycle. It then streams the word out one bit per scan clock, most significant bit first, and drops the enable.

After the shift, the sequencer gives the synthesizer a one-cycle update strobe. It then watches the synthesizer's done flag, first for its rise and then for its fall. When the flag that was captured with the word marks a changed divider or loop setting, a fixed-length reset pulse goes to the synthesizer once the update has finished. A one-cycle completion pulse ends the run, and `busy` clears. If the done flag hangs in either wait phase for too long, the run is abandoned and an error flag is raised. Runs can follow one another without limit.

Top module: `clk_synth_reconfig`

## Requirements
- R1: After reset, `scan_en`, `cfg_update`, `synth_reset`, `busy`, `done_pulse` and `err` are all low.
- R2: A `start` seen while `busy` is low is accepted. `busy` rises, and `cfg_word` and `div_changed` are captured at that edge. A `start` seen while `busy` is high is ignored, and later changes on `cfg_word` do not affect the run in progress.
- R3: `scan_en` rises on the edge that accepts `start`. `scan_data` presents bit CFG_W-1 before the second rising edge at which `scan_en` is high, and that edge is the first capture edge. Each later capture edge takes the next lower bit.
- R4: `scan_en` stays high for exactly CFG_W capture edges after the first enabled edge, then goes low.
- R5: `cfg_update` is high for exactly one cycle per run. During that cycle and the cycle before it, `scan_en` is low.
- R6: After the update, the sequencer waits for `scan_done` to go high and then low. It issues no reset and no completion before that falling edge.
- R7: If the captured `div_changed` is 1, `synth_reset` is high for exactly RST_CYC cycles after `scan_done` falls. If it is 0, `synth_reset` never rises.
- R8: `done_pulse` is high for exactly one cycle at the end of a successful run, and `busy` falls at the edge that ends that cycle.
- R9: If `scan_done` stays in one level for TIMEOUT cycles in either wait phase, `err` rises, `busy` falls and no `done_pulse` is issued. `err` stays high until the next accepted `start` clears it.
- R10: Runs may be repeated back to back any number of times, including after a timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock; all logic runs on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin a reconfiguration run |
| cfg_word | input | CFG_W | New configuration word, sampled when start is accepted |
| div_changed | input | 1 | Set when dividers or loop settings change, so a reset is needed |
| scan_done | input | 1 | Synthesizer done flag; high while it applies the update |
| scan_en | output | 1 | Shift enable for the scan chain |
| scan_data | output | 1 | Serial data into the scan chain, MSB first |
| cfg_update | output | 1 | One-cycle strobe that applies the chain contents |
| synth_reset | output | 1 | Reset pulse to the synthesizer |
| busy | output | 1 | High from accepted start until the run ends |
| done_pulse | output | 1 | One-cycle completion indication |
| err | output | 1 | Timeout indication, held until the next accepted start |

## Verification
The bench builds the block with CFG_W = 16, TIMEOUT = 16 and RST_CYC = 4. A short word lets many whole runs, with their bit order and enable timing, fit in a brief simulation. A 16-cycle timeout lets the bench reach the hung-flag path and then check an exact busy length of CFG_W + TIMEOUT + 3 cycles. A behavioural chain model captures bits only from the second enabled edge. It drives the done flag with different rise and fall delays, so the wait states and the conditional reset are each exercised at both short and long latencies.

// File: rtl/rcfg_pkg.sv
package rcfg_pkg;
  typedef enum logic [3:0] {
    S_IDLE,
    S_PRE_EN,
    S_SHIFT,
    S_POST,
    S_UPDATE,
    S_WAIT_HI,
    S_WAIT_LO,
    S_RESET,
    S_DONE
  } rcfg_state_e;
endpackage

// File: rtl/rcfg_shifter.sv
module rcfg_shifter #(
  parameter int W = 144,
  localparam int CW = (W > 1) ? $clog2(W) : 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  output logic         sdo,
  output logic         last
);
  localparam logic [CW-1:0] LAST_IDX = CW'(W - 1);

  logic [W-1:0]  sreg;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg <= '0;
      cnt  <= '0;
    end else if (load) begin
      sreg <= load_val;
      cnt  <= '0;
    end else if (shift) begin
      sreg <= {sreg[W-2:0], 1'b0};
      cnt  <= cnt + 1'b1;
    end
  end

  assign sdo  = sreg[W-1];
  assign last = (cnt == LAST_IDX);
endmodule

// File: rtl/rcfg_timer.sv
module rcfg_timer #(
  parameter int LIMIT = 1024,
  localparam int TW = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic hit
);
  localparam logic [TW-1:0] LAST_CNT = TW'(LIMIT - 1);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (en)    cnt <= cnt + 1'b1;
  end

  assign hit = en && (cnt == LAST_CNT);
endmodule

// File: rtl/clk_synth_reconfig.sv
module clk_synth_reconfig
  import rcfg_pkg::*;
#(
  parameter int CFG_W   = 144,
  parameter int TIMEOUT = 1024,
  parameter int RST_CYC = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             div_changed,
  input  logic             scan_done,
  output logic             scan_en,
  output logic             scan_data,
  output logic             cfg_update,
  output logic             synth_reset,
  output logic             busy,
  output logic             done_pulse,
  output logic             err
);
  rcfg_state_e state;
  logic        chg_q;
  logic        accept, in_wait, last_bit, w_hit, r_hit, w_clr;

  assign accept  = (state == S_IDLE) && start;
  assign in_wait = (state == S_WAIT_HI) || (state == S_WAIT_LO);
  // restart the wait window when the done flag's rise is seen
  assign w_clr   = !in_wait || ((state == S_WAIT_HI) && scan_done);

  rcfg_shifter #(.W(CFG_W)) shifter_i (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .load_val (cfg_word),
    .shift    (state == S_SHIFT),
    .sdo      (scan_data),
    .last     (last_bit)
  );

  rcfg_timer #(.LIMIT(TIMEOUT)) wait_tmr_i (
    .clk (clk),
    .rst (rst),
    .clr (w_clr),
    .en  (in_wait),
    .hit (w_hit)
  );

  rcfg_timer #(.LIMIT(RST_CYC)) rst_tmr_i (
    .clk (clk),
    .rst (rst),
    .clr (state != S_RESET),
    .en  (state == S_RESET),
    .hit (r_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      chg_q       <= 1'b0;
      scan_en     <= 1'b0;
      cfg_update  <= 1'b0;
      synth_reset <= 1'b0;
      busy        <= 1'b0;
      done_pulse  <= 1'b0;
      err         <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          busy    <= 1'b1;
          err     <= 1'b0;
          scan_en <= 1'b1;
          chg_q   <= div_changed;
          state   <= S_PRE_EN;
        end
        S_PRE_EN: state <= S_SHIFT;
        S_SHIFT: if (last_bit) begin
          scan_en <= 1'b0;
          state   <= S_POST;
        end
        S_POST: begin
          cfg_update <= 1'b1;
          state      <= S_UPDATE;
        end
        S_UPDATE: begin
          cfg_update <= 1'b0;
          state      <= S_WAIT_HI;
        end
        S_WAIT_HI: begin
          if (scan_done) state <= S_WAIT_LO;
          else if (w_hit) begin
            err   <= 1'b1;
            busy  <= 1'b0;
            state <= S_IDLE;
          end
        end
        S_WAIT_LO: begin
          if (!scan_done) begin
            if (chg_q) begin
              synth_reset <= 1'b1;
              state       <= S_RESET;
            end else begin
              done_pulse <= 1'b1;
              state      <= S_DONE;
            end
          end else if (w_hit) begin
            err   <= 1'b1;
            busy  <= 1'b0;
            state <= S_IDLE;
          end
        end
        S_RESET: if (r_hit) begin
          synth_reset <= 1'b0;
          done_pulse  <= 1'b1;
          state       <= S_DONE;
        end
        S_DONE: begin
          done_pulse <= 1'b0;
          busy       <= 1'b0;
          state      <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/clk_synth_reconfig_chk.sv
module clk_synth_reconfig_chk (
  input logic clk,
  input logic rst,
  input logic scan_en,
  input logic cfg_update,
  input logic synth_reset,
  input logic busy,
  input logic done_pulse,
  input logic err
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!scan_en && !cfg_update && !synth_reset));

  a_r5_upd_one_cycle: assert property (@(posedge clk) disable iff (rst)
    cfg_update |=> !cfg_update);

  a_r5_upd_after_en_low: assert property (@(posedge clk) disable iff (rst)
    cfg_update |-> (!scan_en && !$past(scan_en)));

  a_r7_reset_alone: assert property (@(posedge clk) disable iff (rst)
    synth_reset |-> (!scan_en && !cfg_update && !done_pulse));

  a_r8_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
    done_pulse |=> (!busy && !done_pulse));

  a_r9_err_no_done: assert property (@(posedge clk) disable iff (rst)
    err |-> !done_pulse);

  a_r9_err_rise_idle: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> !busy);
endmodule

bind clk_synth_reconfig clk_synth_reconfig_chk chk_i (
  .clk         (clk),
  .rst         (rst),
  .scan_en     (scan_en),
  .cfg_update  (cfg_update),
  .synth_reset (synth_reset),
  .busy        (busy),
  .done_pulse  (done_pulse),
  .err         (err)
);

// File: tb/clk_synth_reconfig_tb_top.sv
module clk_synth_reconfig_tb_top;
  localparam int W  = 16;
  localparam int TO = 16;
  localparam int RC = 4;
  localparam int NV = 6;

  // vector: {word[15:0], div_changed, rise delay[2:0], fall delay[2:0]}
  localparam logic [22:0] VEC [NV] = '{
    {16'hA5C3, 1'b0, 3'd0, 3'd1},
    {16'h8001, 1'b1, 3'd2, 3'd3},
    {16'hFFFF, 1'b0, 3'd5, 3'd0},
    {16'h0000, 1'b1, 3'd0, 3'd0},
    {16'h3C96, 1'b1, 3'd7, 3'd7},
    {16'h1234, 1'b0, 3'd3, 3'd5}
  };

  logic clk = 0, rst = 1, start = 0, div_changed = 0, scan_done = 0;
  logic [W-1:0] cfg_word = '0;
  logic scan_en, scan_data, cfg_update, synth_reset, busy, done_pulse, err;

  always #10 clk = ~clk;

  clk_synth_reconfig #(.CFG_W(W), .TIMEOUT(TO), .RST_CYC(RC)) dut_i (
    .clk(clk), .rst(rst), .start(start), .cfg_word(cfg_word),
    .div_changed(div_changed), .scan_done(scan_done), .scan_en(scan_en),
    .scan_data(scan_data), .cfg_update(cfg_update), .synth_reset(synth_reset),
    .busy(busy), .done_pulse(done_pulse), .err(err)
  );

  // synthesizer and scan chain model
  logic         clr_stats = 0, never_done = 0;
  logic [2:0]   d_rise = 0, d_fall = 0, dly = 0;
  logic [1:0]   phase = 0;
  logic         en_prev = 0, upd_bad = 0, rst_early = 0, done_early = 0;
  logic [W-1:0] cap = '0;
  int           bits = 0, upd_cnt = 0, rst_cnt = 0, done_cnt = 0, busy_cnt = 0;

  always @(posedge clk) begin
    if (clr_stats) begin
      bits <= 0; cap <= '0; upd_cnt <= 0; upd_bad <= 0; rst_cnt <= 0;
      done_cnt <= 0; busy_cnt <= 0; rst_early <= 0; done_early <= 0;
    end else begin
      if (scan_en && en_prev) begin
        cap  <= {cap[W-2:0], scan_data};
        bits <= bits + 1;
      end
      if (cfg_update) begin
        upd_cnt <= upd_cnt + 1;
        if (scan_en || en_prev) upd_bad <= 1;
      end
      if (synth_reset) begin
        rst_cnt <= rst_cnt + 1;
        if (scan_done || phase != 0) rst_early <= 1;
      end
      if (done_pulse) begin
        done_cnt <= done_cnt + 1;
        if (scan_done || phase != 0) done_early <= 1;
      end
      if (busy) busy_cnt <= busy_cnt + 1;
    end
    en_prev <= scan_en;
    if (cfg_update && !never_done) begin
      phase <= 1; dly <= d_rise;
    end else if (phase == 1) begin
      if (dly == 0) begin scan_done <= 1; phase <= 2; dly <= d_fall; end
      else dly <= dly - 1;
    end else if (phase == 2) begin
      if (dly == 0) begin scan_done <= 0; phase <= 0; end
      else dly <= dly - 1;
    end
  end

  int n_run = 0, n_fail = 0;
  bit timed_out = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_stats();
    @(negedge clk); clr_stats = 1;
    @(negedge clk); clr_stats = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (!busy) return;
    end
    timed_out = 1;
  endtask

  task automatic launch(input logic [W-1:0] w, input logic chg);
    @(negedge clk);
    cfg_word = w; div_changed = chg; start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic check_run(input logic [W-1:0] w, input logic chg, input string tag);
    chk(cap == w, {tag, " R3 bit order"}, cap, w);
    chk(bits == W, {tag, " R4 bit count"}, bits, W);
    chk(upd_cnt == 1 && !upd_bad, {tag, " R5 update"}, upd_cnt, 1);
    chk(rst_cnt == (chg ? RC : 0) && !rst_early, {tag, " R7 reset len"}, rst_cnt, chg ? RC : 0);
    chk(done_cnt == 1 && !done_early, {tag, " R6 R8 completion"}, done_cnt, 1);
    chk(!err && !busy, {tag, " R10 clean end"}, {err, busy}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk({scan_en, cfg_update, synth_reset, busy, done_pulse, err} == 0,
        "R1 reset state", {scan_en, cfg_update, synth_reset, busy, done_pulse, err}, 0);

    for (int v = 0; v < NV; v++) begin
      d_rise = VEC[v][5:3]; d_fall = VEC[v][2:0];
      clear_stats();
      launch(VEC[v][22:7], VEC[v][6]);
      chk(busy && scan_en, "R2 R3 accept", {busy, scan_en}, 3);
      wait_idle();
      check_run(VEC[v][22:7], VEC[v][6], "vec");
    end

    // start while busy ignored, input word change ignored
    d_rise = 1; d_fall = 2;
    clear_stats();
    launch(16'hC0DE, 1'b0);
    cfg_word = 16'h0BAD; div_changed = 1;
    repeat (3) @(negedge clk);
    start = 1; @(negedge clk); start = 0;
    wait_idle();
    check_run(16'hC0DE, 1'b0, "R2 ignore");
    repeat (3) @(negedge clk);
    chk(!busy && !scan_en, "R2 no second run", {busy, scan_en}, 0);

    // timeout: done flag never rises
    never_done = 1;
    clear_stats();
    launch(16'h5555, 1'b1);
    wait_idle();
    chk(err == 1, "R9 err set", err, 1);
    chk(done_cnt == 0 && rst_cnt == 0, "R9 no completion", done_cnt + rst_cnt, 0);
    chk(busy_cnt == W + TO + 3, "R9 timeout length", busy_cnt, W + TO + 3);
    repeat (4) @(negedge clk);
    chk(err == 1, "R9 err held", err, 1);

    // rerun after timeout clears err
    never_done = 0; d_rise = 0; d_fall = 1;
    clear_stats();
    launch(16'h6E2F, 1'b1);
    chk(err == 0, "R9 err cleared by start", err, 0);
    wait_idle();
    check_run(16'h6E2F, 1'b1, "R10 after timeout");

    // reset mid-run returns outputs low
    clear_stats();
    launch(16'hFACE, 1'b0);
    repeat (4) @(negedge clk);
    rst = 1; @(negedge clk); rst = 0;
    chk({scan_en, busy, done_pulse, err} == 0, "R1 reset mid-run", {scan_en, busy, done_pulse, err}, 0);

    if (timed_out) chk(0, "watchdog", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule